// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers five interrupt sources into a small controller in front of a CPU. Each source drives a one-cycle pulse that latches a pending flag. Software reads and writes the flag and enable registers over a byte-wide register bus. The block then combines the flags with the per-source enables and a global master enable. When at least one enabled flag is set and the master enable is on, it raises an interrupt request and offers the vector address of the most urgent source.

The CPU answers with an acknowledge. On that cycle the block retires the serviced flag and turns off the master enable, so nested dispatch cannot happen until software or the return path turns it back on. Instruction decode supplies three strobes: enable-all, disable-all and a restore strobe that fires on return from a handler. Stack handling and instruction execution are left to the CPU.

Top module: `irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the flag register reads 0xE0, the enable register reads 0x00, the master enable is off and `irq_req` is low.
- R2: A pulse on `src_pulse[i]` sets flag bit i at the next clock edge. The bits are assigned as follows: bit 0 is vertical blank, bit 1 is display status, bit 2 is timer, bit 3 is serial and bit 4 is joypad. The flag register is read at bus address 0xFF0F.
- R3: A bus write to 0xFF0F replaces flag bits 4:0. Bits 7:5 always read as 1 and ignore writes. A source pulse in the same cycle as the write wins for its own bit.
- R4: The enable register at bus address 0xFFFF is 8 bits wide and reads back what was written. A read of any other address returns 0x00.
- R5: `irq_req` is high exactly when the master enable is on and the AND of enable bits 4:0 with flag bits 4:0 is non-zero.
- R6: The lowest-numbered enabled pending bit wins. `irq_vec` is 0x40 + 8×index, giving 0x40, 0x48, 0x50, 0x58 or 0x60.
- R7: While `irq_req` stays high without `irq_ack` and without a bus write, `irq_vec` does not change, even if a more urgent source becomes pending.
- R8: `irq_ack` while `irq_req` is high clears the flag bit of the presented vector and the master enable at the next edge. `irq_ack` while `irq_req` is low has no effect.
- R9: `ime_set` or `ime_restore` turns the master enable on and `ime_clr` turns it off. When both kinds arrive together, `ime_clr` wins. A dispatch wins over all three strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_pulse | input | 5 | One-cycle request pulse per source |
| bus_addr | input | 16 | Register bus address |
| bus_wr | input | 1 | Register bus write strobe |
| bus_wdata | input | 8 | Register bus write data |
| bus_rdata | output | 8 | Register bus read data (combinational) |
| ime_set | input | 1 | Enable-all strobe from decode |
| ime_clr | input | 1 | Disable-all strobe from decode |
| ime_restore | input | 1 | Master-enable restore strobe on handler return |
| irq_ack | input | 1 | CPU acknowledge of the presented vector |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 8 | Vector address of the presented source |

## Verification
The assertions assume that `irq_ack` is a single-cycle pulse. They also assume that a bus write is the only way a flag or enable bit is lost other than dispatch. The vector-hold property is therefore conditioned on the absence of a bus write in the cycle before. The bench drives every strobe for exactly one cycle, changes inputs only just after the falling edge, and keeps the enable and flag setup writes apart from the cycles in which vector stability is checked.

// File: rtl/irq_pkg.sv
// Package: shared sizes, types and vector constants for the interrupt
// controller. Assumes a fixed set of five sources with vectors spaced evenly.
package irq_pkg;
    localparam int unsigned NSRC     = 5;
    localparam int unsigned IDXW     = $clog2(NSRC);
    localparam logic [7:0]  VEC_BASE = 8'h40;
    localparam logic [7:0]  VEC_STEP = 8'h08;

    typedef logic [NSRC-1:0] src_vec_t;
    typedef logic [IDXW-1:0] src_idx_t;

    // Vector address for a source index.
    function automatic logic [7:0] vec_of(input src_idx_t idx);
        return VEC_BASE + (8'(idx) * VEC_STEP);
    endfunction
endpackage

// File: rtl/irq_flag_reg.sv
// Pending-flag register. Holds one bit per source.
// Assumes the dispatch-clear mask is one-hot or zero.
// Update order within a cycle: dispatch clear, then bus write, then source pulses.
module irq_flag_reg
    import irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t set_pulse,
    input  logic     wr_en,
    input  src_vec_t wr_data,
    input  logic     clr_en,
    input  src_idx_t clr_idx,
    output src_vec_t flags
);
    src_vec_t flags_q;
    src_vec_t flags_d;
    src_vec_t clr_mask;

    // Build the next flag value from clear, write and set sources.
    always_comb begin
        clr_mask = clr_en ? (src_vec_t'(1) << clr_idx) : '0;
        flags_d  = flags_q & ~clr_mask;
        if (wr_en) begin
            flags_d = wr_data;
        end
        flags_d = flags_d | set_pulse;
    end

    // Register the flags with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign flags = flags_q;
endmodule

// File: rtl/irq_enable_reg.sv
// Per-source enable register, written whole from the bus.
// Stores all DW bits; only the low bits take part in arbitration.
module irq_enable_reg #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] en_q
);
    // Capture bus writes; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en) begin
            en_q <= wr_data;
        end
    end
endmodule

// File: rtl/irq_master_en.sv
// Global master enable. Priority, highest first: dispatch clear, disable
// strobe, enable/restore strobes. Assumes every strobe lasts one cycle.
module irq_master_en (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic restore_req,
    input  logic clr_req,
    input  logic dispatch,
    output logic ime
);
    logic ime_q;

    // Resolve the strobes into the next master-enable value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ime_q <= 1'b0;
        end else if (dispatch || clr_req) begin
            ime_q <= 1'b0;
        end else if (set_req || restore_req) begin
            ime_q <= 1'b1;
        end
    end

    assign ime = ime_q;
endmodule

// File: rtl/irq_arbiter.sv
// Fixed-priority arbiter with vector hold. Bit 0 is most urgent. Once a
// vector is presented it is locked while its source stays pending and no
// acknowledge arrives, so a late urgent source does not swap it.
module irq_arbiter
    import irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  src_vec_t   pending,
    input  logic       ime,
    input  logic       ack,
    output logic       req,
    output logic [7:0] vec,
    output logic       disp_en,
    output src_idx_t   disp_idx
);
    logic [NSRC:0] blocked;
    src_vec_t      grant;
    src_idx_t      top_idx;
    src_idx_t      sel_idx;
    logic          lock_vld_q;
    src_idx_t      lock_idx_q;
    logic          hold;

    // Priority chain: a bit is granted when no lower bit is pending.
    assign blocked[0] = 1'b0;
    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_chain
            assign grant[i]     = pending[i] & ~blocked[i];
            assign blocked[i+1] = blocked[i] | pending[i];
        end
    endgenerate

    // Encode the one-hot grant into an index.
    always_comb begin
        top_idx = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (grant[i]) begin
                top_idx = top_idx | src_idx_t'(i);
            end
        end
    end

    // Choose between the locked source and the current winner.
    always_comb begin
        hold    = lock_vld_q && ((pending & (src_vec_t'(1) << lock_idx_q)) != '0);
        sel_idx = hold ? lock_idx_q : top_idx;
    end

    assign req      = ime & (|pending);
    assign vec      = vec_of(sel_idx);
    assign disp_en  = req & ack;
    assign disp_idx = sel_idx;

    // Remember the presented source while the request waits for acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_vld_q <= 1'b0;
            lock_idx_q <= '0;
        end else begin
            lock_vld_q <= req & ~ack;
            lock_idx_q <= sel_idx;
        end
    end
endmodule

// File: rtl/irq_ctrl.sv
// Top of the interrupt controller: register bus decode, flags, enables,
// master enable and arbiter. Bus reads are combinational on the address.
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int unsigned   AW          = 16,
    parameter int unsigned   DW          = 8,
    parameter logic [AW-1:0] FLAG_ADDR   = 16'hFF0F,
    parameter logic [AW-1:0] ENABLE_ADDR = 16'hFFFF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_pulse,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic            ime_set,
    input  logic            ime_clr,
    input  logic            ime_restore,
    input  logic            irq_ack,
    output logic            irq_req,
    output logic [7:0]      irq_vec
);
    localparam int unsigned PADW = DW - NSRC;

    logic      hit_flag;
    logic      hit_en;
    src_vec_t  flag_q;
    logic [DW-1:0] en_q;
    src_vec_t  pending;
    logic      ime_q;
    logic      disp_en;
    src_idx_t  disp_idx;

    assign hit_flag = (bus_addr == FLAG_ADDR);
    assign hit_en   = (bus_addr == ENABLE_ADDR);

    irq_flag_reg i_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (src_pulse),
        .wr_en     (bus_wr & hit_flag),
        .wr_data   (bus_wdata[NSRC-1:0]),
        .clr_en    (disp_en),
        .clr_idx   (disp_idx),
        .flags     (flag_q)
    );

    irq_enable_reg #(.DW(DW)) i_enable (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr & hit_en),
        .wr_data (bus_wdata),
        .en_q    (en_q)
    );

    irq_master_en i_master (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_req     (ime_set),
        .restore_req (ime_restore),
        .clr_req     (ime_clr),
        .dispatch    (disp_en),
        .ime         (ime_q)
    );

    assign pending = en_q[NSRC-1:0] & flag_q;

    irq_arbiter i_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .pending  (pending),
        .ime      (ime_q),
        .ack      (irq_ack),
        .req      (irq_req),
        .vec      (irq_vec),
        .disp_en  (disp_en),
        .disp_idx (disp_idx)
    );

    // Read mux: unused flag bits read as ones.
    always_comb begin
        if (hit_flag) begin
            bus_rdata = {{PADW{1'b1}}, flag_q};
        end else if (hit_en) begin
            bus_rdata = en_q;
        end else begin
            bus_rdata = '0;
        end
    end
endmodule

// File: rtl/irq_ctrl_chk.sv
// Checker for irq_ctrl, bound to the top. It observes the ports plus the
// master enable and flag state. Assumes acknowledge is a one-cycle pulse.
module irq_ctrl_chk
    import irq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input src_vec_t   src_pulse,
    input logic       bus_wr,
    input logic       ime_set,
    input logic       ime_clr,
    input logic       irq_ack,
    input logic       irq_req,
    input logic [7:0] irq_vec,
    input logic       ime,
    input src_vec_t   flags
);
    // A request is never raised with the master enable off.
    p_req_needs_ime_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ime);

    // A presented vector is one of the five legal addresses.
    p_vec_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec[2:0] == 3'b000 && irq_vec >= 8'h40 && irq_vec <= 8'h60));

    // The vector holds while the request waits.
    p_vec_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack && !bus_wr) |=> (!irq_req || $stable(irq_vec)));

    // Dispatch turns the master enable off.
    p_dispatch_ime_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack) |=> !ime);

    // Every pulsed source is pending in the following cycle.
    p_pulse_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_pulse != '0) |=> ((flags & $past(src_pulse)) == $past(src_pulse)));

    // A lone enable strobe turns the master enable on.
    p_ime_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ime_set && !ime_clr && !(irq_req && irq_ack)) |=> ime);
endmodule

bind irq_ctrl irq_ctrl_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_pulse (src_pulse),
    .bus_wr    (bus_wr),
    .ime_set   (ime_set),
    .ime_clr   (ime_clr),
    .irq_ack   (irq_ack),
    .irq_req   (irq_req),
    .irq_vec   (irq_vec),
    .ime       (ime_q),
    .flags     (flag_q)
);

// File: tb/test_irq_ctrl.sv
// Bench for irq_ctrl: a table walk for arbitration, then directed cases.
module test_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] A_FLAG = 16'hFF0F;
    localparam logic [15:0] A_EN   = 16'hFFFF;
    localparam int NROWS = 9;
    // Row: en[22:15] pulses[14:10] ime[9] exp_req[8] exp_vec[7:0]
    localparam logic [22:0] TABLE [NROWS] = '{
        {8'h1F, 5'h1F, 1'b1, 1'b1, 8'h40},
        {8'h1E, 5'h1F, 1'b1, 1'b1, 8'h48},
        {8'h1C, 5'h1C, 1'b1, 1'b1, 8'h50},
        {8'h18, 5'h0A, 1'b1, 1'b1, 8'h58},
        {8'h10, 5'h10, 1'b1, 1'b1, 8'h60},
        {8'h1F, 5'h00, 1'b1, 1'b0, 8'h00},
        {8'h00, 5'h1F, 1'b1, 1'b0, 8'h00},
        {8'h1F, 5'h14, 1'b0, 1'b0, 8'h00},
        {8'h0F, 5'h1A, 1'b1, 1'b1, 8'h48}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  src_pulse = '0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        ime_set = 1'b0;
    logic        ime_clr = 1'b0;
    logic        ime_restore = 1'b0;
    logic        irq_ack = 1'b0;
    logic        irq_req;
    logic [7:0]  irq_vec;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_ctrl i_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ime_set(ime_set), .ime_clr(ime_clr),
        .ime_restore(ime_restore), .irq_ack(irq_ack),
        .irq_req(irq_req), .irq_vec(irq_vec)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [4:0] m);
        src_pulse = m;
        tick();
        src_pulse = '0;
    endtask

    initial begin
        logic [7:0] rd;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        bus_read(A_FLAG, rd); chk("R1 flag reset", rd, 8'hE0);
        bus_read(A_EN, rd);   chk("R1 enable reset", rd, 8'h00);
        chk("R1 req reset", {7'd0, irq_req}, 8'h00);

        // R6 R5 table walk
        for (int r = 0; r < NROWS; r++) begin
            logic [22:0] row;
            row = TABLE[r];
            bus_write(A_FLAG, 8'h00);
            bus_write(A_EN, row[22:15]);
            src_pulse = row[14:10];
            ime_set = row[9];
            ime_clr = ~row[9];
            tick();
            src_pulse = '0; ime_set = 1'b0; ime_clr = 1'b0;
            chk($sformatf("R5 req row %0d", r), {7'd0, irq_req}, {7'd0, row[8]});
            if (row[8]) chk($sformatf("R6 vec row %0d", r), irq_vec, row[7:0]);
        end

        // R2 / R3 flag register behaviour
        ime_clr = 1'b1; tick(); ime_clr = 1'b0;
        bus_write(A_FLAG, 8'h00);
        pulse(5'h08);
        bus_read(A_FLAG, rd); chk("R2 serial pulse sets bit3", rd, 8'hE8);
        bus_write(A_FLAG, 8'hFF);
        bus_read(A_FLAG, rd); chk("R3 write ones", rd, 8'hFF);
        bus_write(A_FLAG, 8'h00);
        bus_read(A_FLAG, rd); chk("R3 high bits ignore write", rd, 8'hE0);
        src_pulse = 5'h04;
        bus_write(A_FLAG, 8'h00);
        src_pulse = '0;
        bus_read(A_FLAG, rd); chk("R3 pulse beats write", rd, 8'hE4);

        // R4 enable register and unmapped read
        bus_write(A_EN, 8'hA5);
        bus_read(A_EN, rd); chk("R4 enable readback", rd, 8'hA5);
        bus_read(16'h1234, rd); chk("R4 unmapped read", rd, 8'h00);

        // R7 vector hold, R8 dispatch
        bus_write(A_FLAG, 8'h00);
        bus_write(A_EN, 8'h1F);
        ime_set = 1'b1; src_pulse = 5'h08; tick();
        ime_set = 1'b0; src_pulse = '0;
        chk("R6 serial vector", irq_vec, 8'h58);
        pulse(5'h01);
        chk("R7 req still high", {7'd0, irq_req}, 8'h01);
        chk("R7 vector held", irq_vec, 8'h58);
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
        chk("R8 req drops after dispatch", {7'd0, irq_req}, 8'h00);
        bus_read(A_FLAG, rd); chk("R8 serviced flag cleared", rd, 8'hE1);

        // R9 restore strobe
        ime_restore = 1'b1; tick(); ime_restore = 1'b0;
        chk("R9 restore raises req", {7'd0, irq_req}, 8'h01);
        chk("R9 vector after restore", irq_vec, 8'h40);

        // R8 ack without request has no effect
        ime_clr = 1'b1; tick(); ime_clr = 1'b0;
        chk("R9 disable drops req", {7'd0, irq_req}, 8'h00);
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
        bus_read(A_FLAG, rd); chk("R8 stray ack ignored", rd, 8'hE1);

        // R9 disable wins over enable
        ime_set = 1'b1; ime_clr = 1'b1; tick(); ime_set = 1'b0; ime_clr = 1'b0;
        chk("R9 clr beats set", {7'd0, irq_req}, 8'h00);

        // R9 dispatch wins over enable strobe
        src_pulse = 5'h02; ime_set = 1'b1; tick(); src_pulse = '0; ime_set = 1'b0;
        chk("R9 req with two pending", {7'd0, irq_req}, 8'h01);
        chk("R6 bit0 before bit1", irq_vec, 8'h40);
        irq_ack = 1'b1; ime_set = 1'b1; tick(); irq_ack = 1'b0; ime_set = 1'b0;
        chk("R9 dispatch beats set", {7'd0, irq_req}, 8'h00);
        bus_read(A_FLAG, rd); chk("R8 only bit0 retired", rd, 8'hE2);

        // R1 reset mid-run
        rst_n = 1'b0; tick(); rst_n = 1'b1;
        bus_read(A_FLAG, rd); chk("R1 flags after reset", rd, 8'hE0);
        bus_read(A_EN, rd);   chk("R1 enable after reset", rd, 8'h00);

        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
        end
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule